// File: doc/BRIEF.md
# Command/Address Parity Checker with Shared Alert

This block sits at the command/address input of a DDR4-style memory device. On every rising clock edge where the chip select is low, it checks one command/address word. The word is made up of the activate pin, the three dual-use command/address lines, the bank group bits, the bank address bits, the low row/column address bits and the parity input. The check runs only when a mode-register parity-enable bit is set.

A parity failure does three things. It drives the active-low alert low for a recovery window of `REC_CYCLES` cycles, with a default of 8. It raises a blocking signal for the same window, so command execution is held. It also sets a sticky status bit. Commands that arrive while the block is blocked are not checked.

A separate strobe from the write data path reports a CRC error. That strobe pulls the same alert low for a fixed `CRC_PULSE` cycles, with a default of 6. When both sources are active at once, the alert stays low until the later of the two ends.

Top module: `cap_alert_checker`

## Requirements
- R1: When the asynchronous active-low reset is asserted, the block goes idle at once, even between clock edges: `alert_n_o`=1, `cmd_block_o`=0 and `err_sticky_o`=0.
- R2: The check uses even parity. A word is in error when the XOR of `act_n_i`, `ras_a16_i`, `cas_a15_i`, `we_a14_i`, `bg_i`, `ba_i`, `addr_i` and `par_i` equals 1.
- R3: When `par_en_i`=0, `par_i` is ignored and no parity error is ever flagged.
- R4: A cycle with `cs_n_i`=1 is never checked, whatever the values on `par_i` and the address lines.
- R5: A word in error that is sampled at clock edge N drives `alert_n_o` low and `cmd_block_o` high from edge N up to edge N+REC_CYCLES. That is exactly REC_CYCLES cycles.
- R6: A word sampled while `cmd_block_o`=1 is not checked. It neither extends the recovery window nor sets the status bit.
- R7: A `crc_err_i` strobe at edge M drives `alert_n_o` low for exactly CRC_PULSE cycles. It leaves `cmd_block_o` at 0.
- R8: When a CRC error and a parity recovery overlap, `alert_n_o` stays low until the later of the two windows ends.
- R9: A parity error sets `err_sticky_o`. The bit stays set until reset, or until `sticky_clr_i` is sampled high at an edge where no new error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| act_n_i | input | 1 | Activate pin |
| ras_a16_i | input | 1 | Dual-use row strobe / address bit 16 |
| cas_a15_i | input | 1 | Dual-use column strobe / address bit 15 |
| we_a14_i | input | 1 | Dual-use write enable / address bit 14 |
| bg_i | input | BG_W | Bank group bits |
| ba_i | input | BA_W | Bank address bits |
| addr_i | input | ADDR_LO_W | Low row/column address bits |
| par_i | input | 1 | Parity input |
| par_en_i | input | 1 | Mode-register parity enable |
| crc_err_i | input | 1 | Write CRC error strobe |
| sticky_clr_i | input | 1 | Clears the sticky status bit |
| alert_n_o | output | 1 | Shared active-low alert |
| err_sticky_o | output | 1 | Sticky parity-error status |
| cmd_block_o | output | 1 | Holds command execution during recovery |

## Verification
Every registered result is due on the first clock edge after the stimulus. The alert, the blocking signal and the status bit all change at the edge that samples the word or the strobe. The bench therefore drives its inputs on falling edges and reads the outputs on the next falling edge. Window lengths are measured by counting consecutive low samples, one per cycle, after the triggering edge. The asynchronous reset is the one result that is not tied to an edge, so it is checked a few nanoseconds after reset falls, before any clock edge can occur.

// File: rtl/cap_pkg.sv
// Shared helpers for the command/address parity checker.
// Assumes: counters hold values from 0 up to their load value inclusive.
package cap_pkg;
    // Bits needed to hold the value n (at least 1).
    function automatic int cap_cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/cap_parity_tree.sv
// Parity reduction over a command/address word.
// Assumes: even parity; the output is 1 when the number of ones is odd (error).
module cap_parity_tree #(
    parameter int W = 23
) (
    input  logic [W-1:0] bits_i,
    output logic         odd_o
);
    // Pairwise XOR tree built level by level.
    localparam int LEVELS = (W < 2) ? 1 : $clog2(W);
    localparam int PAD    = 1 << LEVELS;

    logic [PAD-1:0] stage [LEVELS+1];

    // Pad the word out to a power of two with zeros.
    always_comb stage[0] = {{(PAD-W){1'b0}}, bits_i};

    genvar lv, k;
    generate
        for (lv = 0; lv < LEVELS; lv++) begin : g_lvl
            for (k = 0; k < PAD; k++) begin : g_bit
                if (k < (PAD >> (lv + 1))) begin : g_xor
                    assign stage[lv+1][k] = stage[lv][2*k] ^ stage[lv][2*k+1];
                end else begin : g_zero
                    assign stage[lv+1][k] = 1'b0;
                end
            end
        end
    endgenerate

    assign odd_o = stage[LEVELS][0];
endmodule

// File: rtl/cap_countdown.sv
// Loadable down-counter that reports busy while nonzero.
// Assumes: the load value LOAD_VAL >= 1; a load overrides the decrement.
module cap_countdown #(
    parameter int LOAD_VAL = 8
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic load_i,
    output logic busy_o
);
    localparam int CW = cap_pkg::cap_cnt_w(LOAD_VAL);
    localparam logic [CW-1:0] LOAD = CW'(LOAD_VAL);

    logic [CW-1:0] cnt_q;

    // Reload on request, otherwise count down to zero.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)            cnt_q <= '0;
        else if (load_i)         cnt_q <= LOAD;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/cap_sticky.sv
// Sticky status flag with set priority over clear.
// Assumes: set and clear are sampled on the same edge.
module cap_sticky (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // Hold the flag until an explicit clear with no new set.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)    flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/cap_alert_checker.sv
// Command/address parity checker driving a shared active-low alert.
// A parity error opens a recovery window (alert low, commands blocked);
// a CRC strobe gives a fixed alert pulse; the alert is the AND of both.
// Assumes: inputs are synchronous to clk_i; reset is asynchronous, active low.
module cap_alert_checker #(
    parameter int ADDR_LO_W  = 14,
    parameter int BG_W       = 2,
    parameter int BA_W       = 2,
    parameter int REC_CYCLES = 8,
    parameter int CRC_PULSE  = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_n_i,
    input  logic                 cs_n_i,
    input  logic                 act_n_i,
    input  logic                 ras_a16_i,
    input  logic                 cas_a15_i,
    input  logic                 we_a14_i,
    input  logic [BG_W-1:0]      bg_i,
    input  logic [BA_W-1:0]      ba_i,
    input  logic [ADDR_LO_W-1:0] addr_i,
    input  logic                 par_i,
    input  logic                 par_en_i,
    input  logic                 crc_err_i,
    input  logic                 sticky_clr_i,
    output logic                 alert_n_o,
    output logic                 err_sticky_o,
    output logic                 cmd_block_o
);
    localparam int WORD_W = 4 + BG_W + BA_W + ADDR_LO_W + 1;

    logic [WORD_W-1:0] word;
    logic              word_odd;
    logic              check_en;
    logic              par_err;
    logic              rec_busy;
    logic              crc_busy;

    // Gather every covered line plus the parity bit into one word.
    always_comb word = {act_n_i, ras_a16_i, cas_a15_i, we_a14_i,
                        bg_i, ba_i, addr_i, par_i};

    cap_parity_tree #(.W(WORD_W)) u_tree (
        .bits_i (word),
        .odd_o  (word_odd)
    );

    // Check only selected, enabled, unblocked cycles.
    always_comb begin
        check_en = !cs_n_i && par_en_i && !rec_busy;
        par_err  = check_en && word_odd;
    end

    cap_countdown #(.LOAD_VAL(REC_CYCLES)) u_recovery (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .load_i  (par_err),
        .busy_o  (rec_busy)
    );

    cap_countdown #(.LOAD_VAL(CRC_PULSE)) u_crc_pulse (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .load_i  (crc_err_i),
        .busy_o  (crc_busy)
    );

    cap_sticky u_status (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .set_i   (par_err),
        .clr_i   (sticky_clr_i),
        .flag_o  (err_sticky_o)
    );

    // Wired-AND of the two alert sources.
    always_comb begin
        alert_n_o   = !(rec_busy || crc_busy);
        cmd_block_o = rec_busy;
    end
endmodule

// File: rtl/cap_alert_checker_sva.sv
// Property checker for cap_alert_checker, attached by bind.
module cap_alert_checker_sva (
    input logic clk_i,
    input logic rst_n_i,
    input logic cs_n_i,
    input logic par_en_i,
    input logic crc_err_i,
    input logic sticky_clr_i,
    input logic alert_n_o,
    input logic err_sticky_o,
    input logic cmd_block_o
);
    // R5: recovery always shows on the alert.
    a_r5_block_implies_alert: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cmd_block_o |-> !alert_n_o);

    // R4: an unselected idle cycle raises nothing.
    a_r4_cs_high_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cs_n_i && alert_n_o && !crc_err_i) |=> alert_n_o);

    // R3: parity disabled never flags.
    a_r3_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!par_en_i && alert_n_o && !crc_err_i) |=> alert_n_o);

    // R7: CRC strobe pulls the alert low on the next cycle.
    a_r7_crc_pulls_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        crc_err_i |=> !alert_n_o);

    // R9: status holds without a clear.
    a_r9_sticky_holds: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (err_sticky_o && !sticky_clr_i) |=> err_sticky_o);

    // R6/R9: the status bit can only rise with a new recovery window.
    a_r6_sticky_rise_blocks: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(err_sticky_o) |-> $rose(cmd_block_o));
endmodule

bind cap_alert_checker cap_alert_checker_sva u_sva (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .cs_n_i       (cs_n_i),
    .par_en_i     (par_en_i),
    .crc_err_i    (crc_err_i),
    .sticky_clr_i (sticky_clr_i),
    .alert_n_o    (alert_n_o),
    .err_sticky_o (err_sticky_o),
    .cmd_block_o  (cmd_block_o)
);

// File: tb/cap_alert_checker_tb_top.sv
module cap_alert_checker_tb_top;
    localparam int REC = 8;
    localparam int CRC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, act_n = 1'b1, ras = 1'b1, cas = 1'b1, we = 1'b1;
    logic [1:0]  bg = '0, ba = '0;
    logic [13:0] addr = '0;
    logic        par = 1'b0, par_en = 1'b1, crc = 1'b0, clr = 1'b0;
    logic        alert_n, sticky, block;

    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    cap_alert_checker #(.REC_CYCLES(REC), .CRC_PULSE(CRC)) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .cs_n_i(cs_n), .act_n_i(act_n),
        .ras_a16_i(ras), .cas_a15_i(cas), .we_a14_i(we), .bg_i(bg), .ba_i(ba),
        .addr_i(addr), .par_i(par), .par_en_i(par_en), .crc_err_i(crc),
        .sticky_clr_i(clr), .alert_n_o(alert_n), .err_sticky_o(sticky),
        .cmd_block_o(block));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present a word for the coming edge (call at a falling edge).
    task automatic put_word(input logic c, input logic en, input logic [21:0] d, input logic p);
        cs_n = c; par_en = en; par = p;
        {act_n, ras, cas, we, bg, ba, addr} = d;
    endtask

    task automatic go_idle();
        cs_n = 1'b1; par = 1'b0; crc = 1'b0; clr = 1'b0; par_en = 1'b1;
    endtask

    // Count consecutive low samples, one per falling edge.
    task automatic count_low(output int n_alert, output int n_block);
        n_alert = 0; n_block = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            go_idle();
            if (block) n_block++;
            if (!alert_n) n_alert++;
            else break;
        end
    endtask

    task automatic clear_status();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    // {cs_n, par_en, word[21:0], par, expect_error}
    localparam int NV = 10;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 1'b1, 22'h000000, 1'b0, 1'b0},  // R2 all zero valid
        {1'b0, 1'b1, 22'h000000, 1'b1, 1'b1},  // R2 parity bit alone
        {1'b0, 1'b1, 22'h000001, 1'b1, 1'b0},  // R2 one address bit covered
        {1'b0, 1'b1, 22'h3FFFFF, 1'b0, 1'b0},  // R2 all ones, even
        {1'b0, 1'b1, 22'h3FFFFF, 1'b1, 1'b1},  // R2 all ones + parity
        {1'b0, 1'b0, 22'h000000, 1'b1, 1'b0},  // R3 disabled
        {1'b1, 1'b1, 22'h000000, 1'b1, 1'b0},  // R4 not selected
        {1'b0, 1'b1, 22'h200000, 1'b0, 1'b1},  // R2 activate bit covered
        {1'b0, 1'b1, 22'h155555, 1'b1, 1'b0},  // R2 odd pattern fixed by parity
        {1'b0, 1'b0, 22'h000003, 1'b0, 1'b0}   // R3 disabled, even word
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        int na, nb;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 alert", alert_n, 1);
        check("R1 block", block, 0);
        check("R1 sticky", sticky, 0);
        rst_n = 1'b1;

        // Table of vectors
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            put_word(VEC[v][25], VEC[v][24], VEC[v][23:2], VEC[v][1]);
            @(negedge clk);
            go_idle();
            check($sformatf("R2 vec%0d alert", v), alert_n, !VEC[v][0]);
            check($sformatf("R9 vec%0d sticky", v), sticky, VEC[v][0]);
            repeat (REC + 1) @(negedge clk);
            clear_status();
            check("R9 cleared", sticky, 0);
        end

        // R5: recovery window length
        @(negedge clk); put_word(1'b0, 1'b1, 22'h0, 1'b1);
        count_low(na, nb);
        check("R5 alert window", na, REC);
        check("R5 block window", nb, REC);
        check("R9 sticky holds", sticky, 1);
        repeat (3) @(negedge clk);
        check("R9 sticky still held", sticky, 1);
        clear_status();
        check("R9 clear", sticky, 0);

        // R6: bad word during recovery is not checked
        @(negedge clk); put_word(1'b0, 1'b1, 22'h0, 1'b1);
        @(negedge clk); go_idle(); clr = 1'b1;             // clear during window
        @(negedge clk); clr = 1'b0; put_word(1'b0, 1'b1, 22'h0, 1'b1);
        na = 2;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); go_idle();
            if (!alert_n) na++; else break;
        end
        check("R6 window not extended", na, REC);
        check("R6 sticky not set", sticky, 0);

        // R7: CRC pulse
        @(negedge clk); crc = 1'b1;
        count_low(na, nb);
        check("R7 crc width", na, CRC);
        check("R7 no block", nb, 0);

        // R8: CRC late inside recovery extends
        @(negedge clk); put_word(1'b0, 1'b1, 22'h0, 1'b1);
        na = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); go_idle();
            if (i == 4) crc = 1'b1;                        // strobe at edge N+5
            if (!alert_n) na++; else break;
        end
        check("R8 crc extends recovery", na, 11);
        clear_status();

        // R8: parity error inside CRC pulse extends
        @(negedge clk); crc = 1'b1;
        @(negedge clk); crc = 1'b0; put_word(1'b0, 1'b1, 22'h0, 1'b1);
        na = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); go_idle();
            if (!alert_n) na++; else break;
        end
        check("R8 recovery extends crc", na, 1 + REC);

        // R1: async reset mid-recovery
        @(negedge clk); put_word(1'b0, 1'b1, 22'h0, 1'b1);
        @(negedge clk); go_idle();
        check("R5 low before reset", alert_n, 0);
        #1 rst_n = 1'b0;
        #1;
        check("R1 async alert", alert_n, 1);
        check("R1 async block", block, 0);
        check("R1 async sticky", sticky, 0);
        @(negedge clk); rst_n = 1'b1;

        // R4: CS high with toggling parity leaves everything quiet
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); put_word(1'b1, 1'b1, 22'h1, i[0]);
        end
        @(negedge clk); go_idle();
        check("R4 alert quiet", alert_n, 1);
        check("R4 sticky quiet", sticky, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule